// File: doc/BRIEF.md
# Indirect Codec Control Register Bank

This block is the control-register bank of an audio codec, seen from a word-addressed bus with separate read and write strobes. Sixteen 32-bit direct registers sit in a 64-byte window, and the bus byte address is divided by four to pick one of them. Direct slot 0 holds a pointer. Its low five bits select one of thirty-two 8-bit indirect registers. Direct slot 1 is not a storage location. It is a window through which the selected indirect register is read and written.

Each indirect index can carry its own access rule. One index always reads as zero. Two indices ignore writes. One index keeps a single writable bit and merges a fixed version code into every write. Among the direct slots, one ignores writes and another holds a control value. Setting bit 0 of that control value returns the whole bank to its reset contents. Reads are combinational while the read strobe is high. Writes take effect on the clock edge when the write strobe is high. The interrupt output exists only for pin compatibility and is always low.

Top module: `codec_regbank`

## Requirements
- R1: After hardware reset, every direct slot reads 0x00000000. Indirect index 12 reads 0x0000008A, index 25 reads 0x000000A0, and every other index reads 0.
- R2: Direct slots other than 1, 2 and 4 store all 32 written bits and return them on read.
- R3: Slot = byte address bits [5:2]. Address bits [1:0] have no effect on which register is read.
- R4: The indirect index is bits [4:0] of slot 0. Slot 0 still reads back all 32 bits that were written to it.
- R5: A read at slot 1 returns the selected indirect register, zero-extended to 32 bits. A write at slot 1 stores wdata[7:0] there.
- R6: A read of indirect index 3 always returns 0.
- R7: Writes to indirect indices 11 and 25 leave their contents unchanged.
- R8: A write to indirect index 12 stores (wdata[7:0] AND 0x40) OR 0x8A.
- R9: Writes to slot 2 are ignored, and slot 2 always reads 0.
- R10: A write to slot 4 stores wdata AND 0x7F. If wdata[0] is 1, every other register first returns to its R1 value in that same cycle, and slot 4 then shows the masked value.
- R11: rdata is 0 whenever rd_en is low.
- R12: irq is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 6 | Byte address within the 64-byte window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data |
| irq | output | 1 | Interrupt, held low |

## Verification
The assertions assume that a single cycle never carries both a read and a write. They also assume that read data is compared against the contents present before any write in that cycle. The bench therefore issues exactly one access per cycle and leaves the bus idle between phases. The byte-lane check requires two back-to-back reads that differ only in addr[1:0], with no write between them. The bench builds that pattern on purpose. The stimulus writes to slot 0 with upper pointer bits set, so that the five-bit index masking is exercised. Soft resets arrive both with and without bit 0 set, and only after the bank has been filled with non-reset values.

// File: rtl/codec_regbank.sv
module codec_regbank #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int IREG_W = 8,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int SLOT_W = ADDR_W - 2;
  localparam int NDIR   = 1 << SLOT_W;
  localparam int NIND   = 1 << IDX_W;
  localparam logic [SLOT_W-1:0] S_PTR  = SLOT_W'(0);
  localparam logic [SLOT_W-1:0] S_WIN  = SLOT_W'(1);
  localparam logic [SLOT_W-1:0] S_RO   = SLOT_W'(2);
  localparam logic [SLOT_W-1:0] S_CTL  = SLOT_W'(4);
  localparam logic [IDX_W-1:0]  I_WO   = IDX_W'(3);
  localparam logic [IDX_W-1:0]  I_RO_A = IDX_W'(11);
  localparam logic [IDX_W-1:0]  I_MRG  = IDX_W'(12);
  localparam logic [IDX_W-1:0]  I_RO_B = IDX_W'(25);
  localparam logic [IREG_W-1:0] CDC_ID = IREG_W'(8'h8A);
  localparam logic [IREG_W-1:0] CHIP_ID = IREG_W'(8'hA0);
  localparam logic [IREG_W-1:0] MRG_KEEP = IREG_W'(8'h40);
  localparam logic [DATA_W-1:0] CTL_MASK = DATA_W'(32'h7F);

  logic [DATA_W-1:0] dreg [NDIR];
  logic [IREG_W-1:0] ireg [NIND];

  wire [SLOT_W-1:0] slot = addr[ADDR_W-1:2];
  wire [IDX_W-1:0]  idx  = dreg[S_PTR][IDX_W-1:0];
  wire wr_win   = wr_en && slot == S_WIN;
  wire soft_clr = wr_en && slot == S_CTL && wdata[0];

  function automatic logic [IREG_W-1:0] ind_init(int i);
    if (i == int'(I_MRG)) return CDC_ID;
    if (i == int'(I_RO_B)) return CHIP_ID;
    return '0;
  endfunction

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (slot == S_WIN)
        rdata = (idx == I_WO) ? '0 : {{(DATA_W-IREG_W){1'b0}}, ireg[idx]};
      else
        rdata = dreg[slot];
    end
  end

  assign irq = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NDIR; i++) dreg[i] <= '0;
      for (int i = 0; i < NIND; i++) ireg[i] <= ind_init(i);
    end else if (wr_en) begin
      if (soft_clr) begin
        for (int i = 0; i < NDIR; i++) dreg[i] <= '0;
        for (int i = 0; i < NIND; i++) ireg[i] <= ind_init(i);
        dreg[S_CTL] <= wdata & CTL_MASK;
      end else begin
        case (slot)
          S_WIN: begin
            if (idx == I_MRG)
              ireg[idx] <= (wdata[IREG_W-1:0] & MRG_KEEP) | CDC_ID;
            else if (idx != I_RO_A && idx != I_RO_B)
              ireg[idx] <= wdata[IREG_W-1:0];
          end
          S_RO:  ;
          S_CTL: dreg[S_CTL] <= wdata & CTL_MASK;
          default: dreg[slot] <= wdata;
        endcase
      end
    end
  end

  p_lane_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && $past(rd_en) && !$past(wr_en) &&
     addr[ADDR_W-1:2] == $past(addr[ADDR_W-1:2]) && addr[1:0] != $past(addr[1:0]))
    |-> rdata == $past(rdata));

  p_wo_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && slot == S_WIN && idx == I_WO) |-> rdata == '0);

  p_ro_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_win && (idx == I_RO_A || idx == I_RO_B))
    |=> ($stable(ireg[I_RO_A]) && $stable(ireg[I_RO_B])));

  p_merge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_win && idx == I_MRG)
    |=> ireg[I_MRG] == (($past(wdata[IREG_W-1:0]) & MRG_KEEP) | CDC_ID));

  p_slot2_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && slot == S_RO) |-> rdata == '0);

  p_soft_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (dreg[S_PTR] == '0 && ireg[I_MRG] == CDC_ID &&
                  ireg[I_RO_B] == CHIP_ID && dreg[S_CTL] == ($past(wdata) & CTL_MASK)));

  p_idle_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == '0);
endmodule

// File: tb/codec_regbank_bench.sv
`timescale 1ns/1ps
module codec_regbank_bench;
  logic clk = 1'b0, rst_n = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int n_chk = 0, n_fail = 0;

  bit [31:0] md [16];
  bit [7:0]  mi [32];

  always #2 clk = ~clk;

  codec_regbank u_codec_regbank (.clk, .rst_n, .rd_en, .wr_en, .addr, .wdata, .rdata, .irq);

  function automatic void model_reset();
    foreach (md[i]) md[i] = 0;
    foreach (mi[i]) mi[i] = 0;
    mi[12] = 8'h8A;
    mi[25] = 8'hA0;
  endfunction

  function automatic bit [31:0] model_read(bit [5:0] a);
    int s = a >> 2;
    int k = md[0] % 32;
    if (s == 1) return (k == 3) ? 0 : {24'b0, mi[k]};
    if (s == 2) return 0;
    return md[s];
  endfunction

  function automatic void model_write(bit [5:0] a, bit [31:0] d);
    int s = a >> 2;
    int k = md[0] % 32;
    if (s == 1) begin
      if (k == 12) mi[k] = (d[7:0] & 8'h40) | 8'h8A;
      else if (k != 11 && k != 25) mi[k] = d[7:0];
    end else if (s == 4) begin
      if (d[0]) model_reset();
      md[4] = d & 32'h7F;
    end else if (s != 2) md[s] = d;
  endfunction

  task automatic check(string tag, bit [31:0] act, bit [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic step(bit r, bit w, bit [5:0] a, bit [31:0] d, string tag);
    @(negedge clk);
    rd_en = r; wr_en = w; addr = a; wdata = d;
    #1;
    check(tag, rdata, r ? model_read(a) : 32'h0);
    check("R12", {31'b0, irq}, 32'h0);
    @(posedge clk);
    if (w) model_write(a, d);
  endtask

  task automatic wr(bit [5:0] a, bit [31:0] d, string tag); step(0, 1, a, d, tag); endtask
  task automatic rd(bit [5:0] a, string tag); step(1, 0, a, 0, tag); endtask

  task automatic sweep(string tag);
    for (int s = 0; s < 16; s++) rd(6'(s*4), tag);
    for (int k = 0; k < 32; k++) begin
      wr(6'h00, 32'(k), tag);
      rd(6'h04, tag);
    end
  endtask

  initial begin
    #(200000*4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sweep("R1");
    for (int s = 3; s < 16; s++) if (s != 4) wr(6'(s*4), 32'hA5000000 ^ (32'(s) * 32'h01010101), "R2");
    for (int s = 3; s < 16; s++) if (s != 4) rd(6'(s*4), "R2");
    rd(6'h0C, "R3"); rd(6'h0F, "R3"); rd(6'h0D, "R3"); rd(6'h17, "R3");
    wr(6'h00, 32'hFFFFFFE7, "R4"); rd(6'h00, "R4");
    wr(6'h04, 32'h123456C3, "R5"); rd(6'h04, "R5"); rd(6'h05, "R5");
    for (int k = 0; k < 32; k++) begin
      wr(6'h00, 32'(k) | 32'hC0, "R4");
      wr(6'h04, 32'(8'hFF - k*7), "R5");
      rd(6'h04, "R5");
    end
    wr(6'h00, 32'd3, "R6"); wr(6'h04, 32'h5A, "R6"); rd(6'h04, "R6");
    wr(6'h00, 32'd11, "R7"); wr(6'h04, 32'h11, "R7"); rd(6'h04, "R7");
    wr(6'h00, 32'd25, "R7"); wr(6'h04, 32'h33, "R7"); rd(6'h04, "R7");
    wr(6'h00, 32'd12, "R8"); wr(6'h04, 32'hFF, "R8"); rd(6'h04, "R8");
    wr(6'h04, 32'h00, "R8"); rd(6'h04, "R8");
    wr(6'h04, 32'h40, "R8"); rd(6'h04, "R8");
    wr(6'h08, 32'hDEADBEEF, "R9"); rd(6'h08, "R9");
    step(0, 0, 6'h0C, 0, "R11"); step(0, 0, 6'h04, 0, "R11");
    wr(6'h10, 32'hFFFFFFFE, "R10"); rd(6'h10, "R10"); rd(6'h14, "R10");
    wr(6'h00, 32'd7, "R10");
    wr(6'h10, 32'h00000081, "R10");
    rd(6'h10, "R10");
    sweep("R10");
    wr(6'h00, 32'd9, "R1"); wr(6'h04, 32'h77, "R1"); wr(6'h20, 32'h1234, "R1");
    @(negedge clk); rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
    model_reset();
    @(negedge clk); rst_n = 1'b1;
    sweep("R1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule